// File: doc/BRIEF.md
# Pulse-Interval Gap Decoder

This block recovers the command bits that a reader sends to a tag by briefly switching off its carrier. It runs on the field clock and takes one input, `gap_i`. This input is already synchronized and is high while the carrier is absent. The block times two things: each carrier-off stretch (a gap) and each carrier-on stretch between two gaps (an interval). The first gap of a frame only opens the frame. Every gap after it ends an interval, and the interval's length gives a data bit: a short interval is a 0 and a longer one is a 1.

The bits leave the block as a one-cycle strobe with the decoded value beside it. A frame ends when the carrier stays on too long, and the block then gives a one-cycle end-of-frame pulse. An error flag marks a frame that contained a malformed interval or gap. It stays high until the end-of-frame pulse, so that the command layer downstream can drop the whole frame. A mode input picks one of two timing sets, normal or fast. The mode is taken to be stable for the whole of a frame.

Top module: `pid_gap_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bit_valid_o`, `bit_o`, `eof_o` and `err_o` are all 0 after that edge, and the decoder is idle.
- R2: In idle, a gap of 10 to 50 clocks opens a frame. A gap of any other length is discarded, and the decoder stays idle.
- R3: In normal mode (`fast_i` = 0), an interval of 16 to 31 clocks followed by a gap produces one strobe with `bit_o` = 0.
- R4: In normal mode, an interval of 48 to 63 clocks followed by a gap produces one strobe with `bit_o` = 1.
- R5: In fast mode (`fast_i` = 1), an interval of 8 to 15 clocks decodes as 0, and an interval of 24 to 31 clocks decodes as 1.
- R6: When an interval inside a frame is too long for both bit windows but does not reach the timeout, no strobe is produced and `err_o` rises.
- R7: Inside a frame, a data gap must last 8 to 30 clocks in normal mode and 8 to 20 clocks in fast mode. A data gap of any other length raises `err_o`.
- R8: If the carrier stays on for 65 clocks in normal mode (33 in fast mode), `eof_o` pulses for exactly one cycle on the edge that samples the last of those clocks, and the decoder returns to idle.
- R9: After an error, later gaps produce no strobes. `err_o` stays high up to and including the `eof_o` cycle and is low one cycle later.
- R10: The gap-length counter saturates. A gap of 64 or more clocks therefore counts as too long and never wraps back into the start-gap window (for example, a gap of 74 clocks does not open a frame).
- R11: `bit_valid_o` rises only on the edge after the first high sample of a gap and lasts one cycle. The bits come out in the order their intervals arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gap_i | input | 1 | Synchronized gap detect, high while the carrier is off |
| fast_i | input | 1 | Timing set select: 0 normal, 1 fast |
| bit_valid_o | output | 1 | One-cycle strobe for each decoded bit |
| bit_o | output | 1 | Value of the last decoded bit |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| err_o | output | 1 | Frame error flag, held until end of frame |

## Verification
Two functions can fall in the same cycle: the end-of-frame timeout and the error flag that is being held. After an interval or gap error, the decoder drains until the carrier has been on long enough. On that edge `eof_o` fires while `err_o` is still high, and on the next edge `err_o` must clear. The bench provokes this with sweeps over the interval and gap lengths that step just past each window edge. For every rejected frame, it records whether the error flag was high in the pulse cycle and whether it was still high one cycle later.

// File: rtl/pid_pkg.sv
// Shared types for the pulse-interval gap decoder.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pid_pkg;

    // Decoder phase: idle, carrier-on between gaps, inside a data gap, draining after an error
    typedef enum logic [1:0] {
        PID_IDLE  = 2'd0,
        PID_LOW   = 2'd1,
        PID_HIGH  = 2'd2,
        PID_DRAIN = 2'd3
    } pid_state_e;

    // Classification of one measured interval
    typedef enum logic [1:0] {
        PID_CLS_ZERO = 2'd0,
        PID_CLS_ONE  = 2'd1,
        PID_CLS_BAD  = 2'd2
    } pid_cls_e;

endpackage

// File: rtl/pid_run_counter.sv
// Saturating run-length counter.
// Counts the samples of one run of a level. When a new run begins, it
// reloads to 1. While the level is absent, it holds the length of the
// last run. Assumes restart_i is only high together with hit_i.
module pid_run_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         restart_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Advance the run length, reload at the start of a run, never wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (hit_i) begin
            if (restart_i) begin
                cnt_o <= W'(1);
            end else if (cnt_o != CNT_MAX) begin
                cnt_o <= cnt_o + W'(1);
            end
        end
    end

endmodule

// File: rtl/pid_window.sv
// Timing-window classifier.
// A purely combinational block. It compares the last interval length
// and the last gap length against the window set picked by fast_i.
// Assumes that every window limit fits the counter widths it is compared in.
module pid_window
    import pid_pkg::*;
#(
    parameter int INT_W     = 7,
    parameter int GAP_W     = 6,
    parameter int N_ZERO_LO = 16,
    parameter int N_ZERO_HI = 31,
    parameter int N_ONE_LO  = 48,
    parameter int N_ONE_HI  = 63,
    parameter int N_GAP_LO  = 8,
    parameter int N_GAP_HI  = 30,
    parameter int N_TIMEOUT = 64,
    parameter int F_ZERO_LO = 8,
    parameter int F_ZERO_HI = 15,
    parameter int F_ONE_LO  = 24,
    parameter int F_ONE_HI  = 31,
    parameter int F_GAP_LO  = 8,
    parameter int F_GAP_HI  = 20,
    parameter int F_TIMEOUT = 32,
    parameter int START_LO  = 10,
    parameter int START_HI  = 50
) (
    input  logic             fast_i,
    input  logic [INT_W-1:0] int_len_i,
    input  logic [GAP_W-1:0] gap_len_i,
    output pid_cls_e         int_cls_o,
    output logic             gap_ok_o,
    output logic             start_ok_o,
    output logic             timeout_o
);

    localparam logic [INT_W-1:0] NZL = INT_W'(N_ZERO_LO);
    localparam logic [INT_W-1:0] NZH = INT_W'(N_ZERO_HI);
    localparam logic [INT_W-1:0] NOL = INT_W'(N_ONE_LO);
    localparam logic [INT_W-1:0] NOH = INT_W'(N_ONE_HI);
    localparam logic [INT_W-1:0] NTO = INT_W'(N_TIMEOUT);
    localparam logic [INT_W-1:0] FZL = INT_W'(F_ZERO_LO);
    localparam logic [INT_W-1:0] FZH = INT_W'(F_ZERO_HI);
    localparam logic [INT_W-1:0] FOL = INT_W'(F_ONE_LO);
    localparam logic [INT_W-1:0] FOH = INT_W'(F_ONE_HI);
    localparam logic [INT_W-1:0] FTO = INT_W'(F_TIMEOUT);
    localparam logic [GAP_W-1:0] NGL = GAP_W'(N_GAP_LO);
    localparam logic [GAP_W-1:0] NGH = GAP_W'(N_GAP_HI);
    localparam logic [GAP_W-1:0] FGL = GAP_W'(F_GAP_LO);
    localparam logic [GAP_W-1:0] FGH = GAP_W'(F_GAP_HI);
    localparam logic [GAP_W-1:0] SGL = GAP_W'(START_LO);
    localparam logic [GAP_W-1:0] SGH = GAP_W'(START_HI);

    logic [INT_W-1:0] z_lo, z_hi, o_lo, o_hi, to_lim;
    logic [GAP_W-1:0] g_lo, g_hi;

    // Pick the limit set for the current timing mode
    always_comb begin
        z_lo   = fast_i ? FZL : NZL;
        z_hi   = fast_i ? FZH : NZH;
        o_lo   = fast_i ? FOL : NOL;
        o_hi   = fast_i ? FOH : NOH;
        to_lim = fast_i ? FTO : NTO;
        g_lo   = fast_i ? FGL : NGL;
        g_hi   = fast_i ? FGH : NGH;
    end

    // Sort the last interval into zero, one or invalid
    always_comb begin
        if (int_len_i >= z_lo && int_len_i <= z_hi) begin
            int_cls_o = PID_CLS_ZERO;
        end else if (int_len_i >= o_lo && int_len_i <= o_hi) begin
            int_cls_o = PID_CLS_ONE;
        end else begin
            int_cls_o = PID_CLS_BAD;
        end
    end

    // Judge gap lengths and the carrier-on timeout
    always_comb begin
        gap_ok_o   = (gap_len_i >= g_lo) && (gap_len_i <= g_hi);
        start_ok_o = (gap_len_i >= SGL) && (gap_len_i <= SGH);
        timeout_o  = (int_len_i >= to_lim);
    end

endmodule

// File: rtl/pid_fsm.sv
// Frame sequencer for the gap decoder.
// Opens a frame on a valid start gap, emits one bit per classified
// interval, checks each data gap, drains after an error and closes the
// frame on the carrier-on timeout. Assumes that timeout_i reports a
// previous run length that is at least the limit, so the current sample
// makes the run exceed it.
module pid_fsm
    import pid_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     gap_i,
    input  logic     gap_q_i,
    input  pid_cls_e int_cls_i,
    input  logic     gap_ok_i,
    input  logic     start_ok_i,
    input  logic     timeout_i,
    output logic     bit_valid_o,
    output logic     bit_o,
    output logic     eof_o,
    output logic     err_o
);

    pid_state_e state_q;
    logic       fall_s;
    logic       expire_s;

    // Gap end, and a carrier-on run that has grown past the limit
    always_comb begin
        fall_s   = !gap_i && gap_q_i;
        expire_s = !gap_i && !gap_q_i && timeout_i;
    end

    // State walk with registered strobes and the held error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PID_IDLE;
            bit_valid_o <= 1'b0;
            bit_o       <= 1'b0;
            eof_o       <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            bit_valid_o <= 1'b0;
            eof_o       <= 1'b0;
            unique case (state_q)
                PID_IDLE: begin
                    err_o <= 1'b0;
                    if (fall_s && start_ok_i) begin
                        state_q <= PID_LOW;
                    end
                end
                PID_LOW: begin
                    if (gap_i) begin
                        if (int_cls_i == PID_CLS_BAD) begin
                            err_o   <= 1'b1;
                            state_q <= PID_DRAIN;
                        end else begin
                            bit_valid_o <= 1'b1;
                            bit_o       <= (int_cls_i == PID_CLS_ONE);
                            state_q     <= PID_HIGH;
                        end
                    end else if (expire_s) begin
                        eof_o   <= 1'b1;
                        state_q <= PID_IDLE;
                    end
                end
                PID_HIGH: begin
                    if (fall_s) begin
                        if (gap_ok_i) begin
                            state_q <= PID_LOW;
                        end else begin
                            err_o   <= 1'b1;
                            state_q <= PID_DRAIN;
                        end
                    end
                end
                PID_DRAIN: begin
                    if (expire_s) begin
                        eof_o   <= 1'b1;
                        state_q <= PID_IDLE;
                    end
                end
                default: state_q <= PID_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pid_gap_decoder.sv
// Pulse-interval gap decoder, top level.
// Registers the gap input once to find its edges. Times each carrier-on
// and carrier-off run with saturating counters, classifies the runs and
// sequences the frame. Assumes that gap_i is already synchronous to clk
// and that fast_i is static during a frame.
module pid_gap_decoder
    import pid_pkg::*;
#(
    parameter int N_ZERO_LO = 16,
    parameter int N_ZERO_HI = 31,
    parameter int N_ONE_LO  = 48,
    parameter int N_ONE_HI  = 63,
    parameter int N_GAP_LO  = 8,
    parameter int N_GAP_HI  = 30,
    parameter int N_TIMEOUT = 64,
    parameter int F_ZERO_LO = 8,
    parameter int F_ZERO_HI = 15,
    parameter int F_ONE_LO  = 24,
    parameter int F_ONE_HI  = 31,
    parameter int F_GAP_LO  = 8,
    parameter int F_GAP_HI  = 20,
    parameter int F_TIMEOUT = 32,
    parameter int START_LO  = 10,
    parameter int START_HI  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_i,
    input  logic fast_i,
    output logic bit_valid_o,
    output logic bit_o,
    output logic eof_o,
    output logic err_o
);

    localparam int INT_W = $clog2(N_TIMEOUT + 2);
    localparam int GAP_W = $clog2(START_HI + 2);

    logic             gap_q;
    logic             rise_s;
    logic             fall_s;
    logic [INT_W-1:0] int_len;
    logic [GAP_W-1:0] gap_len;
    pid_cls_e         int_cls;
    logic             gap_ok;
    logic             start_ok;
    logic             timeout;

    // Keep the previous gap sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= 1'b0;
        end else begin
            gap_q <= gap_i;
        end
    end

    // Gap begin and gap end for one sample
    always_comb begin
        rise_s = gap_i && !gap_q;
        fall_s = !gap_i && gap_q;
    end

    pid_run_counter #(.W(INT_W)) u_low_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (!gap_i),
        .restart_i (fall_s),
        .cnt_o     (int_len)
    );

    pid_run_counter #(.W(GAP_W)) u_high_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (gap_i),
        .restart_i (rise_s),
        .cnt_o     (gap_len)
    );

    pid_window #(
        .INT_W     (INT_W),
        .GAP_W     (GAP_W),
        .N_ZERO_LO (N_ZERO_LO),
        .N_ZERO_HI (N_ZERO_HI),
        .N_ONE_LO  (N_ONE_LO),
        .N_ONE_HI  (N_ONE_HI),
        .N_GAP_LO  (N_GAP_LO),
        .N_GAP_HI  (N_GAP_HI),
        .N_TIMEOUT (N_TIMEOUT),
        .F_ZERO_LO (F_ZERO_LO),
        .F_ZERO_HI (F_ZERO_HI),
        .F_ONE_LO  (F_ONE_LO),
        .F_ONE_HI  (F_ONE_HI),
        .F_GAP_LO  (F_GAP_LO),
        .F_GAP_HI  (F_GAP_HI),
        .F_TIMEOUT (F_TIMEOUT),
        .START_LO  (START_LO),
        .START_HI  (START_HI)
    ) u_window (
        .fast_i     (fast_i),
        .int_len_i  (int_len),
        .gap_len_i  (gap_len),
        .int_cls_o  (int_cls),
        .gap_ok_o   (gap_ok),
        .start_ok_o (start_ok),
        .timeout_o  (timeout)
    );

    pid_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gap_i       (gap_i),
        .gap_q_i     (gap_q),
        .int_cls_i   (int_cls),
        .gap_ok_i    (gap_ok),
        .start_ok_i  (start_ok),
        .timeout_i   (timeout),
        .bit_valid_o (bit_valid_o),
        .bit_o       (bit_o),
        .eof_o       (eof_o),
        .err_o       (err_o)
    );

endmodule

// File: rtl/pid_gap_decoder_chk.sv
// Property checker for the gap decoder, attached to the top by bind.
// It observes only the ports of the top module.
module pid_gap_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic gap_i,
    input logic bit_valid_o,
    input logic eof_o,
    input logic err_o
);

    // R6: a bit is never emitted while the frame is marked bad
    assert_bit_without_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> !err_o);

    // R8: end of frame is a single-cycle pulse
    assert_eof_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

    // R8: end of frame follows a carrier-on sample
    assert_eof_on_carrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> !$past(gap_i));

    // R9: the error flag holds until the end-of-frame pulse
    assert_err_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !eof_o) |=> err_o);

    // R9: the error flag clears one cycle after end of frame
    assert_err_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !err_o);

    // R11: a strobe follows the first high sample of a gap
    assert_bit_on_gap_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> ($past(gap_i) && !$past(gap_i, 2)));

    // R11: a strobe lasts one cycle
    assert_bit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> !bit_valid_o);

endmodule

bind pid_gap_decoder pid_gap_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gap_i       (gap_i),
    .bit_valid_o (bit_valid_o),
    .eof_o       (eof_o),
    .err_o       (err_o)
);

// File: tb/pid_gap_decoder_bench.sv
// Self-checking bench: sweeps interval, gap and start-gap lengths in both modes.
module pid_gap_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gap_i = 1'b0;
    logic fast_i = 1'b0;
    logic bit_valid_o, bit_o, eof_o, err_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Monitor state
    int          mon_bits = 0;
    logic [63:0] mon_vec = '0;
    int          mon_eof = 0;
    bit          mon_eof_err = 1'b0;
    bit          mon_stuck = 1'b0;
    bit          prev_eof = 1'b0;

    always #5 clk = ~clk;

    pid_gap_decoder u_pid_gap_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .gap_i       (gap_i),
        .fast_i      (fast_i),
        .bit_valid_o (bit_valid_o),
        .bit_o       (bit_o),
        .eof_o       (eof_o),
        .err_o       (err_o)
    );

    // Capture strobes, pulses and the error flag around each pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid_o) begin
                mon_vec  = {mon_vec[62:0], bit_o};
                mon_bits = mon_bits + 1;
            end
            if (prev_eof && err_o) mon_stuck = 1'b1;
            if (eof_o) begin
                mon_eof = mon_eof + 1;
                if (err_o) mon_eof_err = 1'b1;
            end
            prev_eof = eof_o;
        end
    end

    task automatic clear_mon();
        mon_bits = 0; mon_vec = '0; mon_eof = 0;
        mon_eof_err = 1'b0; mon_stuck = 1'b0;
    endtask

    // Hold gap_i at lvl for n clock samples; called at a negedge
    task automatic hold(input logic lvl, input int n);
        gap_i = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic judge(input string req, input int eb, input logic elast,
                         input int ee, input bit eerr);
        bit bad;
        n_checks++;
        bad = (mon_bits != eb) || (mon_eof != ee) || (mon_eof_err != eerr) || mon_stuck;
        if (eb > 0 && mon_vec[0] != elast) bad = 1'b1;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual bits=%0d last=%0b eof=%0d err=%0b stuck=%0b expected bits=%0d last=%0b eof=%0d err=%0b stuck=0",
                     req, mon_bits, mon_vec[0], mon_eof, mon_eof_err, mon_stuck, eb, elast, ee, eerr);
        end
    endtask

    // 0 zero, 1 one, 2 bad, 3 timeout: from R3, R4, R5, R6, R8
    function automatic int expect_cls(input int iv, input bit f);
        int zl, zh, ol, oh, to;
        zl = f ? 8 : 16; zh = f ? 15 : 31; ol = f ? 24 : 48; oh = f ? 31 : 63; to = f ? 32 : 64;
        if (iv > to) return 3;
        if (iv >= zl && iv <= zh) return 0;
        if (iv >= ol && iv <= oh) return 1;
        return 2;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if ({bit_valid_o, bit_o, eof_o, err_o} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1: actual %b expected 0000", {bit_valid_o, bit_o, eof_o, err_o});
        end
        rst_n = 1'b1;
        hold(1'b0, 80);
        n_checks++;
        if ({bit_valid_o, eof_o, err_o} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: actual %b expected 000 after release", {bit_valid_o, eof_o, err_o});
        end

        // R3 R4 R5 R6 R8: interval sweep in both modes
        for (int m = 0; m < 2; m++) begin
            fast_i = m[0];
            for (int iv = 1; iv <= (m == 0 ? 70 : 40); iv++) begin
                int c;
                clear_mon();
                hold(1'b1, 20); hold(1'b0, iv); hold(1'b1, 10); hold(1'b0, 100);
                c = expect_cls(iv, m[0]);
                case (c)
                    0: judge(m ? "R5 zero" : "R3", 1, 1'b0, 1, 1'b0);
                    1: judge(m ? "R5 one" : "R4", 1, 1'b1, 1, 1'b0);
                    2: judge("R6", 0, 1'b0, 1, 1'b1);
                    default: judge("R8 timeout", 0, 1'b0, 2, 1'b0);
                endcase
            end
        end

        // R7 R9: data gap length sweep in both modes
        for (int m = 0; m < 2; m++) begin
            int i0;
            fast_i = m[0];
            i0 = m ? 12 : 20;
            for (int gl = 1; gl <= (m == 0 ? 40 : 25); gl++) begin
                clear_mon();
                hold(1'b1, 20); hold(1'b0, i0); hold(1'b1, gl);
                hold(1'b0, i0); hold(1'b1, 10); hold(1'b0, 100);
                if (gl >= 8 && gl <= (m ? 20 : 30)) judge("R7 ok", 2, 1'b0, 1, 1'b0);
                else judge("R7 R9 bad gap", 1, 1'b0, 1, 1'b1);
            end
        end

        // R2 R10: start gap sweep, normal mode
        fast_i = 1'b0;
        for (int sg = 1; sg <= 80; sg++) begin
            clear_mon();
            hold(1'b1, sg); hold(1'b0, 20); hold(1'b1, 10); hold(1'b0, 100);
            if (sg >= 10 && sg <= 50) judge("R2 accepted", 1, 1'b0, 1, 1'b0);
            else if (sg >= 64) judge("R10 saturated", 0, 1'b0, 1, 1'b0);
            else judge("R2 rejected", 0, 1'b0, 1, 1'b0);
        end

        // R8: end-of-frame timing in cycles after the start gap
        for (int m = 0; m < 2; m++) begin
            int k;
            fast_i = m[0];
            clear_mon();
            hold(1'b1, 20);
            gap_i = 1'b0;
            k = 0;
            do begin @(negedge clk); k++; end while (!eof_o && k < 300);
            n_checks++;
            if (k != (m ? 33 : 65)) begin
                n_fail++;
                $display("FAIL R8: eof after %0d cycles, expected %0d", k, m ? 33 : 65);
            end
            hold(1'b0, 60);
        end

        // R11: long frames with a pseudo-random bit pattern
        for (int m = 0; m < 2; m++) begin
            logic [39:0] expv;
            logic [7:0]  lf;
            fast_i = m[0];
            lf = 8'hA5;
            expv = '0;
            clear_mon();
            hold(1'b1, 25);
            for (int k = 0; k < 40; k++) begin
                int lo, span, iv, gl;
                logic b;
                b  = lf[0];
                lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[4], lf[7:1]};
                lo   = b ? (m ? 24 : 48) : (m ? 8 : 16);
                span = m ? (b ? 8 : 8) : 16;
                iv   = lo + (k * 5) % span;
                gl   = 8 + (k * 3) % (m ? 13 : 23);
                expv = {expv[38:0], b};
                hold(1'b0, iv); hold(1'b1, gl);
            end
            hold(1'b0, 100);
            n_checks++;
            if (mon_bits != 40 || mon_vec[39:0] != expv || mon_eof != 1 || mon_eof_err) begin
                n_fail++;
                $display("FAIL R11: actual bits=%0d vec=%h eof=%0d expected bits=40 vec=%h eof=1",
                         mon_bits, mon_vec[39:0], mon_eof, expv);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule